// File: doc/BRIEF.md
# Serial Port Interrupt Source and Receive Timeout Unit

This block forms the interrupt sources of a synchronous serial port that buffers data in a transmit FIFO and a receive FIFO. It reads the occupancy of both FIFOs and two strobes from the port: one for a completed incoming frame and one for a read from the receive FIFO. From these it derives four conditions:

- receive overrun
- receive idle timeout
- receive FIFO at least half full
- transmit FIFO at least half empty

Software controls the block through a small register bus. The enable mask can be written and read back. The gated status can be read. A clear register acknowledges the two sticky conditions. The gated status bits are also brought out as a port, and their OR drives a single registered interrupt line.

The receive timeout measures idle time in serial bit periods, not in clock cycles. One bit period is `prescale * (rate + 1)` clock cycles. The timeout fires after 32 idle bit periods, so it scales with the configured link speed. The two FIFO-level conditions follow the occupancy inputs directly and go away once the FIFO is serviced.

Top module: `serial_irq_unit`

## Requirements
- R1: After reset the mask register reads 0, the status port `stat` is 0 and `irq_out` is 0.
- R2: A write to address 0 stores `bus_wdata[3:0]` as the enable mask. A read of address 0 returns the mask in bits 3:0, and bits 31:4 read 0.
- R3: When `frame_done` is high while `rx_level` equals the FIFO depth (8), the overrun flag (status bit 0) sets on that clock edge. `frame_done` at a lower level does not set it. Once set, the flag stays set until it is cleared, whatever the level does.
- R4: While `rx_level` is nonzero and neither `rx_pop` nor `frame_done` is seen, the timeout flag (status bit 1) sets on the edge that ends the `32 * P * (rate + 1)`-th such cycle. P is `prescale`, or 1 when `prescale` is 0. The flag fires once per idle stretch and is sticky until cleared.
- R5: An `rx_pop` or a `frame_done` restarts the idle count. While `rx_level` is 0, the idle count is held at zero, so a full timeout period is needed after the FIFO becomes non-empty.
- R6: Raw status bit 2 is 1 exactly when `rx_level >= 4`. Raw status bit 3 is 1 exactly when `tx_level <= 4`. Both follow the levels in the same cycle and have no clear bit.
- R7: `stat[i]` is raw bit i AND mask bit i. A read of address 1 returns `stat` in bits 3:0, with zeros above.
- R8: A write to address 2 clears the overrun flag where `bus_wdata[0]` is 1 and the timeout flag where `bus_wdata[1]` is 1. Zero bits, and bits 3:2, have no effect. Reads of addresses 2 and 3 return 0.
- R9: When a set event and a clear of the same sticky flag fall on the same edge, the flag ends up set.
- R10: `irq_out` equals the OR of `stat`, delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_level | input | 4 | Receive FIFO occupancy (0 to 8) |
| tx_level | input | 4 | Transmit FIFO occupancy (0 to 8) |
| frame_done | input | 1 | One-cycle strobe: a complete frame was received |
| rx_pop | input | 1 | One-cycle strobe: the receive FIFO was read |
| prescale | input | 8 | Clock prescale divisor (0 treated as 1) |
| rate | input | 8 | Serial rate divider; bit period is prescale*(rate+1) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 mask, 1 status, 2 clear, 3 spare |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| stat | output | 4 | Masked status bits |
| irq_out | output | 1 | Registered combined interrupt |

## Verification
A corrupted sticky flag shows on `stat` and on a status read right after the edge where it changes. One clock later it shows on `irq_out`. A wrong idle count shows only when the timeout flag rises: it rises a cycle early, a cycle late, or not at all. The bench therefore samples both sides of the exact expiry edge. It does this for several prescale and rate settings and after each kind of restart. Mistakes in the level compares or the mask gating show on `stat` in the same cycle the level changes.

// File: rtl/sirq_pkg.sv
`timescale 1ns/1ps
package sirq_pkg;
   localparam int unsigned NUM_SRC    = 4;
   localparam int unsigned NUM_STICKY = 2;
   localparam int unsigned SRC_OVR    = 0;
   localparam int unsigned SRC_TOUT   = 1;
   localparam int unsigned SRC_RXH    = 2;
   localparam int unsigned SRC_TXH    = 3;

   typedef enum logic [1:0] {
      REG_MASK  = 2'd0,
      REG_STAT  = 2'd1,
      REG_CLR   = 2'd2,
      REG_SPARE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/sirq_level_cmp.sv
`timescale 1ns/1ps
module sirq_level_cmp #(
   parameter int unsigned FIFO_DEPTH = 8,
   parameter int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic [LVL_W-1:0] rx_level,
   input  logic [LVL_W-1:0] tx_level,
   output logic             rx_half,
   output logic             tx_half,
   output logic             rx_full,
   output logic             rx_empty
);
   localparam int unsigned HALF = FIFO_DEPTH / 2;
   localparam logic [LVL_W-1:0] HALF_LVL = LVL_W'(HALF);
   localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

   if (FIFO_DEPTH < 2 || (FIFO_DEPTH % 2) != 0) begin : g_bad_depth
      $error("sirq_level_cmp: FIFO_DEPTH must be even and at least 2");
   end
   if ((1 << LVL_W) <= FIFO_DEPTH) begin : g_bad_lvl_w
      $error("sirq_level_cmp: LVL_W too narrow for FIFO_DEPTH");
   end

   always_comb begin
      rx_half  = (rx_level >= HALF_LVL);
      tx_half  = (tx_level <= HALF_LVL);
      rx_full  = (rx_level >= FULL_LVL);
      rx_empty = (rx_level == '0);
   end
endmodule

// File: rtl/sirq_bit_timer.sv
`timescale 1ns/1ps
module sirq_bit_timer #(
   parameter int unsigned PRE_W     = 8,
   parameter int unsigned RATE_W    = 8,
   parameter int unsigned TOUT_BITS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic [PRE_W-1:0]  prescale,
   input  logic [RATE_W-1:0] rate,
   output logic              expire
);
   localparam int unsigned BIT_W = (TOUT_BITS > 1) ? $clog2(TOUT_BITS) : 1;
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(TOUT_BITS - 1);

   if (TOUT_BITS < 2) begin : g_bad_tout
      $error("sirq_bit_timer: TOUT_BITS must be at least 2");
   end
   if (PRE_W < 1 || RATE_W < 1) begin : g_bad_w
      $error("sirq_bit_timer: divider widths must be at least 1");
   end

   logic [PRE_W-1:0]  pre_cnt;
   logic [PRE_W-1:0]  pre_last;
   logic [RATE_W-1:0] rate_cnt;
   logic [BIT_W-1:0]  bit_cnt;
   logic              spent_q;
   logic              pre_wrap;
   logic              rate_wrap;
   logic              bit_tick;
   logic              last_bit;

   always_comb begin
      pre_last  = (prescale == '0) ? '0 : prescale - PRE_W'(1);
      pre_wrap  = (pre_cnt == pre_last);
      rate_wrap = (rate_cnt == rate);
      bit_tick  = pre_wrap && rate_wrap;
      last_bit  = (bit_cnt == BIT_LAST);
      expire    = !restart && !spent_q && bit_tick && last_bit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_cnt  <= '0;
         rate_cnt <= '0;
         bit_cnt  <= '0;
         spent_q  <= 1'b0;
      end else if (restart) begin
         pre_cnt  <= '0;
         rate_cnt <= '0;
         bit_cnt  <= '0;
         spent_q  <= 1'b0;
      end else if (!spent_q) begin
         pre_cnt <= pre_wrap ? '0 : pre_cnt + PRE_W'(1);
         if (pre_wrap) begin
            rate_cnt <= rate_wrap ? '0 : rate_cnt + RATE_W'(1);
         end
         if (bit_tick) begin
            if (last_bit) begin
               bit_cnt <= '0;
               spent_q <= 1'b1;
            end else begin
               bit_cnt <= bit_cnt + BIT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/sirq_sticky.sv
`timescale 1ns/1ps
module sirq_sticky #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_evt,
   input  logic [N-1:0] clr_req,
   output logic [N-1:0] flag_q
);
   if (N < 1) begin : g_bad_n
      $error("sirq_sticky: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q[i] <= 1'b0;
         end else if (set_evt[i]) begin
            flag_q[i] <= 1'b1;
         end else if (clr_req[i]) begin
            flag_q[i] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sirq_regs.sv
`timescale 1ns/1ps
module sirq_regs
   import sirq_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_wr,
   input  logic [1:0]            bus_addr,
   input  logic [NUM_SRC-1:0]    wr_bits,
   input  logic [NUM_SRC-1:0]    stat,
   output logic [NUM_SRC-1:0]    mask,
   output logic [NUM_STICKY-1:0] clr_req,
   output logic [DATA_W-1:0]     rdata
);
   if (DATA_W < NUM_SRC) begin : g_bad_data_w
      $error("sirq_regs: DATA_W narrower than the source count");
   end

   reg_sel_e sel;
   logic     wr_mask;
   logic     wr_clr;

   always_comb begin
      sel     = reg_sel_e'(bus_addr);
      wr_mask = bus_wr && (sel == REG_MASK);
      wr_clr  = bus_wr && (sel == REG_CLR);
      clr_req = wr_clr ? wr_bits[NUM_STICKY-1:0] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask <= '0;
      end else if (wr_mask) begin
         mask <= wr_bits;
      end
   end

   always_comb begin
      rdata = '0;
      unique case (sel)
         REG_MASK:  rdata[NUM_SRC-1:0] = mask;
         REG_STAT:  rdata[NUM_SRC-1:0] = stat;
         REG_CLR:   rdata = '0;
         REG_SPARE: rdata = '0;
         default:   rdata = '0;
      endcase
   end
endmodule

// File: rtl/serial_irq_unit.sv
`timescale 1ns/1ps
module serial_irq_unit
   import sirq_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH     = 8,
   parameter int unsigned PRE_W          = 8,
   parameter int unsigned RATE_W         = 8,
   parameter int unsigned TOUT_BITS      = 32,
   parameter int unsigned DATA_W         = 32,
   parameter bit          IRQ_REGISTERED = 1'b1,
   parameter int unsigned LVL_W          = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LVL_W-1:0]  rx_level,
   input  logic [LVL_W-1:0]  tx_level,
   input  logic              frame_done,
   input  logic              rx_pop,
   input  logic [PRE_W-1:0]  prescale,
   input  logic [RATE_W-1:0] rate,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_SRC-1:0] stat,
   output logic              irq_out
);
   logic                  rx_half;
   logic                  tx_half;
   logic                  rx_full;
   logic                  rx_empty;
   logic                  idle_restart;
   logic                  tout_expire;
   logic [NUM_STICKY-1:0] set_evt;
   logic [NUM_STICKY-1:0] clr_req;
   logic [NUM_STICKY-1:0] sticky_q;
   logic [NUM_SRC-1:0]    raw_vec;
   logic [NUM_SRC-1:0]    mask;
   logic                  unused_wdata_hi;

   if (DATA_W > NUM_SRC) begin : g_wdata_hi
      assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_SRC];
   end else begin : g_wdata_exact
      assign unused_wdata_hi = 1'b0;
   end

   sirq_level_cmp #(
      .FIFO_DEPTH (FIFO_DEPTH),
      .LVL_W      (LVL_W)
   ) u_level (
      .rx_level (rx_level),
      .tx_level (tx_level),
      .rx_half  (rx_half),
      .tx_half  (tx_half),
      .rx_full  (rx_full),
      .rx_empty (rx_empty)
   );

   assign idle_restart = rx_pop | frame_done | rx_empty;

   sirq_bit_timer #(
      .PRE_W     (PRE_W),
      .RATE_W    (RATE_W),
      .TOUT_BITS (TOUT_BITS)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (idle_restart),
      .prescale (prescale),
      .rate     (rate),
      .expire   (tout_expire)
   );

   always_comb begin
      set_evt           = '0;
      set_evt[SRC_OVR]  = frame_done & rx_full;
      set_evt[SRC_TOUT] = tout_expire;
   end

   sirq_sticky #(
      .N (NUM_STICKY)
   ) u_sticky (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (set_evt),
      .clr_req (clr_req),
      .flag_q  (sticky_q)
   );

   always_comb begin
      raw_vec           = '0;
      raw_vec[SRC_OVR]  = sticky_q[SRC_OVR];
      raw_vec[SRC_TOUT] = sticky_q[SRC_TOUT];
      raw_vec[SRC_RXH]  = rx_half;
      raw_vec[SRC_TXH]  = tx_half;
      stat              = raw_vec & mask;
   end

   sirq_regs #(
      .DATA_W (DATA_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .wr_bits  (bus_wdata[NUM_SRC-1:0]),
      .stat     (stat),
      .mask     (mask),
      .clr_req  (clr_req),
      .rdata    (bus_rdata)
   );

   if (IRQ_REGISTERED) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_out <= 1'b0;
         end else begin
            irq_out <= |stat;
         end
      end
   end else begin : g_irq_comb
      assign irq_out = |stat;
   end
endmodule

// File: rtl/sirq_checker.sv
`timescale 1ns/1ps
module sirq_checker
   import sirq_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH = 8,
   parameter int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [LVL_W-1:0]   rx_level,
   input logic               frame_done,
   input logic               bus_wr,
   input logic [1:0]         bus_addr,
   input logic               clr_bit0,
   input logic [NUM_SRC-1:0] raw_vec,
   input logic [NUM_SRC-1:0] stat,
   input logic               irq_out
);
   localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);
   localparam logic [LVL_W-1:0] HALF_LVL = LVL_W'(FIFO_DEPTH / 2);

   logic ovr_evt;
   logic ovr_clr;

   assign ovr_evt = frame_done && (rx_level == FULL_LVL);
   assign ovr_clr = bus_wr && (bus_addr == REG_CLR) && clr_bit0;

   p_ovr_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_evt |=> raw_vec[SRC_OVR]);

   p_ovr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_vec[SRC_OVR] && !ovr_clr) |=> raw_vec[SRC_OVR]);

   p_ovr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_clr && !ovr_evt) |=> !raw_vec[SRC_OVR]);

   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_clr && ovr_evt) |=> raw_vec[SRC_OVR]);

   p_tout_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level == '0) |=> !$rose(raw_vec[SRC_TOUT]));

   p_rx_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
      stat[SRC_RXH] |-> (rx_level >= HALF_LVL));

   p_irq_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_out == $past(|stat)));
endmodule

bind serial_irq_unit sirq_checker #(
   .FIFO_DEPTH (FIFO_DEPTH),
   .LVL_W      (LVL_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_level   (rx_level),
   .frame_done (frame_done),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .clr_bit0   (bus_wdata[0]),
   .raw_vec    (raw_vec),
   .stat       (stat),
   .irq_out    (irq_out)
);

// File: tb/serial_irq_unit_tb_top.sv
`timescale 1ns/1ps
module serial_irq_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  rx_level = 4'd0;
   logic [3:0]  tx_level = 4'd8;
   logic        frame_done = 1'b0;
   logic        rx_pop = 1'b0;
   logic [7:0]  prescale = 8'd200;
   logic [7:0]  rate = 8'd255;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = 32'd0;
   logic [31:0] bus_rdata;
   logic [3:0]  stat;
   logic        irq_out;

   int n_run  = 0;
   int n_fail = 0;
   int cyc    = 0;

   always #10 clk = ~clk;

   serial_irq_unit dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_level   (rx_level),
      .tx_level   (tx_level),
      .frame_done (frame_done),
      .rx_pop     (rx_pop),
      .prescale   (prescale),
      .rate       (rate),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .stat       (stat),
      .irq_out    (irq_out)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual=%0d cycles expected<=100000", cyc);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = 32'd0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic pulse_frame();
      @(negedge clk);
      frame_done = 1'b1;
      @(negedge clk);
      frame_done = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      repeat (3) @(negedge clk);
      check("R1 stat in reset", {28'd0, stat}, 32'd0);
      check("R1 irq in reset", {31'd0, irq_out}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      bus_read(2'd0, d);
      check("R1 mask after reset", d, 32'd0);
      check("R1 irq after reset", {31'd0, irq_out}, 32'd0);
   endtask

   task automatic t_mask_regs();
      logic [31:0] d;
      bus_write(2'd0, 32'hFFFF_FFF5);
      bus_read(2'd0, d);
      check("R2 mask readback", d, 32'h5);
      bus_read(2'd1, d);
      check("R7 status read idle", d, 32'h0);
      bus_read(2'd2, d);
      check("R8 clear reg reads 0", d, 32'h0);
      bus_read(2'd3, d);
      check("R8 spare reads 0", d, 32'h0);
      bus_write(2'd0, 32'hF);
   endtask

   task automatic t_overrun();
      logic [31:0] d;
      rx_level = 4'd7;
      pulse_frame();
      check("R3 no overrun below full", {31'd0, stat[0]}, 32'd0);
      rx_level = 4'd8;
      pulse_frame();
      check("R3 overrun at full", {31'd0, stat[0]}, 32'd1);
      rx_level = 4'd2;
      repeat (3) @(negedge clk);
      check("R3 overrun sticky", {31'd0, stat[0]}, 32'd1);
      bus_write(2'd2, 32'h0);
      check("R8 zero write no effect", {31'd0, stat[0]}, 32'd1);
      rx_level = 4'd5;
      bus_write(2'd2, 32'hC);
      check("R8 bits 3:2 leave overrun", {31'd0, stat[0]}, 32'd1);
      check("R8 bits 3:2 leave rx half", {31'd0, stat[2]}, 32'd1);
      bus_write(2'd2, 32'h1);
      check("R8 overrun cleared", {31'd0, stat[0]}, 32'd0);
      bus_read(2'd1, d);
      check("R7 status read", d, 32'h4);
      rx_level = 4'd0;
   endtask

   task automatic t_set_wins();
      rx_level = 4'd8;
      pulse_frame();
      @(negedge clk);
      frame_done = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 32'h1;
      @(negedge clk);
      frame_done = 1'b0; bus_wr = 1'b0; bus_wdata = 32'd0;
      check("R9 set beats clear", {31'd0, stat[0]}, 32'd1);
      bus_write(2'd2, 32'h1);
      check("R9 later clear works", {31'd0, stat[0]}, 32'd0);
      rx_level = 4'd0;
   endtask

   task automatic t_levels();
      logic [31:0] d;
      rx_level = 4'd3; #1;
      check("R6 rx 3 not half", {31'd0, stat[2]}, 32'd0);
      rx_level = 4'd4; #1;
      check("R6 rx 4 half", {31'd0, stat[2]}, 32'd1);
      tx_level = 4'd5; #1;
      check("R6 tx 5 not half empty", {31'd0, stat[3]}, 32'd0);
      tx_level = 4'd4; #1;
      check("R6 tx 4 half empty", {31'd0, stat[3]}, 32'd1);
      tx_level = 4'd0; #1;
      check("R6 tx 0 half empty", {31'd0, stat[3]}, 32'd1);
      tx_level = 4'd8;
      bus_write(2'd0, 32'h0);
      bus_read(2'd1, d);
      check("R7 masked off reads 0", d, 32'h0);
      check("R7 masked off stat", {28'd0, stat}, 32'h0);
      bus_write(2'd0, 32'h4);
      rx_level = 4'd3;
      @(negedge clk);
      check("R10 irq low", {31'd0, irq_out}, 32'd0);
      rx_level = 4'd4; #1;
      check("R10 stat immediate", {28'd0, stat}, 32'h4);
      check("R10 irq not yet", {31'd0, irq_out}, 32'd0);
      @(negedge clk);
      check("R10 irq one clock later", {31'd0, irq_out}, 32'd1);
      rx_level = 4'd3; #1;
      check("R10 irq holds before edge", {31'd0, irq_out}, 32'd1);
      @(negedge clk);
      check("R10 irq drops", {31'd0, irq_out}, 32'd0);
      rx_level = 4'd0;
      bus_write(2'd0, 32'hF);
   endtask

   task automatic setup_timer(input logic [7:0] p, input logic [7:0] r);
      @(negedge clk);
      rx_level = 4'd0;
      prescale = p; rate = r;
      @(negedge clk);
   endtask

   task automatic t_timeout(input logic [7:0] p, input logic [7:0] r, input string tag);
      int n;
      n = ((p == 0) ? 1 : int'(p)) * (int'(r) + 1) * 32;
      setup_timer(p, r);
      rx_level = 4'd1;
      repeat (n - 1) @(negedge clk);
      check({tag, " not yet expired"}, {31'd0, stat[1]}, 32'd0);
      @(negedge clk);
      check({tag, " expired"}, {31'd0, stat[1]}, 32'd1);
      bus_write(2'd2, 32'h2);
      check("R8 timeout cleared", {31'd0, stat[1]}, 32'd0);
      repeat (n + 10) @(negedge clk);
      check("R4 fires once per idle stretch", {31'd0, stat[1]}, 32'd0);
      rx_level = 4'd0;
   endtask

   task automatic t_restart(input bit use_pop);
      setup_timer(8'd2, 8'd0);
      rx_level = 4'd1;
      repeat (40) @(negedge clk);
      if (use_pop) rx_pop = 1'b1; else frame_done = 1'b1;
      @(negedge clk);
      rx_pop = 1'b0; frame_done = 1'b0;
      repeat (63) @(negedge clk);
      check(use_pop ? "R5 pop restart early" : "R5 frame restart early", {31'd0, stat[1]}, 32'd0);
      @(negedge clk);
      check(use_pop ? "R5 pop restart expiry" : "R5 frame restart expiry", {31'd0, stat[1]}, 32'd1);
      bus_write(2'd2, 32'h2);
      rx_level = 4'd0;
   endtask

   task automatic t_empty_hold();
      setup_timer(8'd2, 8'd0);
      rx_level = 4'd1;
      repeat (50) @(negedge clk);
      rx_level = 4'd0;
      repeat (100) @(negedge clk);
      check("R5 no timeout while empty", {31'd0, stat[1]}, 32'd0);
      rx_level = 4'd1;
      repeat (63) @(negedge clk);
      check("R5 empty resets count", {31'd0, stat[1]}, 32'd0);
      @(negedge clk);
      check("R5 full period after empty", {31'd0, stat[1]}, 32'd1);
      bus_write(2'd2, 32'h2);
      rx_level = 4'd0;
   endtask

   initial begin
      t_reset();
      t_mask_regs();
      t_overrun();
      t_set_wins();
      t_levels();
      t_timeout(8'd2, 8'd0, "R4 p2 r0");
      t_timeout(8'd4, 8'd2, "R4 p4 r2");
      t_timeout(8'd0, 8'd1, "R4 p0 r1");
      t_restart(1'b1);
      t_restart(1'b0);
      t_empty_hold();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule